// File: doc/BRIEF.md
# Scanline Prescaled IRQ Counter

This block is an 8-bit up-counter that drives a level-sensitive interrupt request to the CPU. It advances on CPU cycles, which arrive as a one-cycle `cpu_tick` enable on the fabric clock. There are two counting modes. In the first, the counter steps on every enabled CPU cycle. In the second, it steps once per video scanline. The scanline rate comes from a signed prescaler: a line is 341 pixel clocks, and each CPU cycle spends three of them.

Software controls the block through four write strobes that share one data bus:
- two writes fill the reload value one nibble at a time;
- one write sets the mode, which holds the repeat, enable and cycle-mode bits;
- one write acknowledges the interrupt.

When the counter wraps past its top value, it reloads from the latch and raises the IRQ. The IRQ stays high until software writes the mode or acknowledge register.

Top module: `irq_tick_counter`

## Requirements
- R1: A write on `wr_lo` loads latch bits 3:0 from `wr_data[3:0]`. A write on `wr_hi` loads latch bits 7:4 from `wr_data[3:0]`. Data bits 7:4 are ignored by both writes.
- R2: A write on `wr_mode` stores `wr_data[2:0]` as the mode: bit 0 is repeat, bit 1 is enable and bit 2 is cycle mode. The same write clears the IRQ on the next edge and discards any `cpu_tick` in that cycle. If bit 1 of the written data is set, the counter also loads the latch value and the prescaler is set to 341.
- R3: A write on `wr_ack` clears the IRQ. With `HONOR_REPEAT=1`, it also copies the repeat bit into the enable bit, so a repeat bit of 0 stops counting and a repeat bit of 1 keeps the counter running.
- R4: With `HONOR_REPEAT=0`, a write on `wr_ack` only clears the IRQ and leaves the enable bit unchanged.
- R5: While enable is 0, the counter and the prescaler hold their values and no IRQ is raised.
- R6: With enable set and cycle mode set, the counter increments on every `cpu_tick`.
- R7: With enable set and cycle mode clear, each `cpu_tick` subtracts 3 from the prescaler. When the result is 0 or less, 341 is added back and the counter steps once. Starting from a mode write, the counter therefore steps after 114, 114 and then 113 ticks, and the pattern repeats.
- R8: When the counter steps from 0xFF, it reloads from the latch and the IRQ rises on the same edge.
- R9: Once high, the IRQ stays high until a mode or acknowledge write clears it. Latch writes and further counter wraps do not clear it.
- R10: After reset, the latch, mode, counter and prescaler are zero and the IRQ is low. With no writes, `cpu_tick` has no effect. If counting is enabled without a reload, 256 steps are needed before the first IRQ.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_tick | input | 1 | One-cycle pulse per CPU cycle |
| wr_lo | input | 1 | Write strobe for the latch low nibble |
| wr_hi | input | 1 | Write strobe for the latch high nibble |
| wr_mode | input | 1 | Write strobe for the mode register |
| wr_ack | input | 1 | Write strobe for the interrupt acknowledge |
| wr_data | input | 8 | Write data shared by all four strobes |
| irq | output | 1 | Level interrupt request |

## Verification
The only visible output is the IRQ line, so any internal fault shows up as an interrupt in the wrong cycle or as an IRQ that is missing or stuck.

- A wrong latch nibble or a wrong reload shifts the next rising edge by a whole number of ticks. In cycle mode this appears within one counter period.
- A prescaler off by one pixel clock breaks the 114/114/113 spacing. This surfaces only after two or three scanlines, so the bench runs three scanline periods in a row.
- Faults in the enable handling or the repeat copy appear as an IRQ that fires or stays silent after the next acknowledge.

// File: rtl/irqc_pkg.sv
// Package: shared mode-register layout for the prescaled IRQ counter.
// Assumes: software writes the mode bits on data[2:0] in the order below.
package irqc_pkg;

    // Bit positions of the mode register as seen on the write data bus.
    localparam int RPT_BIT = 0;
    localparam int EN_BIT  = 1;
    localparam int CYC_BIT = 2;
    localparam int MODE_W  = 3;

    // Stored mode: cyc is bit 2, en is bit 1, rpt is bit 0.
    typedef struct packed {
        logic cyc;   // 1: count every CPU cycle, 0: count scanlines
        logic en;    // counter running
        logic rpt;   // value copied into en by an acknowledge
    } mode_t;

endpackage

// File: rtl/irqc_regs.sv
// Module: irqc_regs
// Holds the reload latch (filled one nibble at a time) and the mode register.
// Also applies the acknowledge-time copy of repeat into enable.
// Assumes: CNT_W is even, and at most one strobe is active per cycle.
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter bit HONOR_REPEAT = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic                  wr_mode,
    input  logic                  wr_ack,
    input  logic [CNT_W/2-1:0]    wr_data,
    output logic [CNT_W-1:0]      latch_q,
    output mode_t                 mode_q
);
    localparam int HALF = CNT_W / 2;

    logic ack_en;

    // Enable value taken on an acknowledge: the repeat bit, or unchanged.
    generate
        if (HONOR_REPEAT) begin : g_repeat
            assign ack_en = mode_q.rpt;
        end else begin : g_no_repeat
            assign ack_en = mode_q.en;
        end
    endgenerate

    // Latch nibble writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (wr_lo) begin
            latch_q[HALF-1:0] <= wr_data;
        end else if (wr_hi) begin
            latch_q[CNT_W-1:HALF] <= wr_data;
        end
    end

    // Mode register: a full write, or an acknowledge update of the enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_mode) begin
            mode_q <= mode_t'(wr_data[MODE_W-1:0]);
        end else if (wr_ack) begin
            mode_q.en <= ack_en;
        end
    end

endmodule

// File: rtl/irqc_prescaler.sv
// Module: irqc_prescaler
// Signed pixel-clock budget for one scanline. Each step spends DOTS_PER_TICK.
// When the budget drops to zero or below, it is refilled by LINE_DOTS and
// one fire pulse is produced.
// Assumes: PRE_W is wide enough to hold LINE_DOTS as a positive signed value.
module irqc_prescaler #(
    parameter int PRE_W         = 10,
    parameter int LINE_DOTS     = 341,
    parameter int DOTS_PER_TICK = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic                    step,
    output logic                    fire,
    output logic signed [PRE_W-1:0] pre_q
);
    localparam logic signed [PRE_W-1:0] LINE_S = PRE_W'(LINE_DOTS);
    localparam logic signed [PRE_W-1:0] TICK_S = PRE_W'(DOTS_PER_TICK);

    logic signed [PRE_W-1:0] spent;

    // Budget left after this tick, and whether it is exhausted.
    always_comb begin
        spent = pre_q - TICK_S;
        fire  = step && (spent <= 0);
    end

    // Budget register: reload on a mode write, otherwise spend and refill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (load) begin
            pre_q <= LINE_S;
        end else if (step) begin
            pre_q <= fire ? spent + LINE_S : spent;
        end
    end

endmodule

// File: rtl/irqc_counter.sv
// Module: irqc_counter
// Up-counter that reloads from the latch when it wraps past all-ones.
// Assumes: load and step are never both needed in one cycle; load wins.
module irqc_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [CNT_W-1:0] latch,
    output logic             wrap,
    output logic [CNT_W-1:0] cnt_q
);
    // Wrap detection: a step taken from the all-ones value.
    always_comb begin
        wrap = step && !load && (cnt_q == {CNT_W{1'b1}});
    end

    // Count register: load, reload on wrap, or increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load || wrap) begin
            cnt_q <= latch;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/irq_tick_counter.sv
// Module: irq_tick_counter (top)
// Prescaled interrupt counter. Ticks advance the counter directly (cycle
// mode) or through the scanline prescaler. A wrap raises a sticky IRQ.
// Assumes: cpu_tick is a one-cycle pulse; a tick that coincides with a mode
// write is dropped; a wrap in the same cycle as an acknowledge keeps IRQ high.
module irq_tick_counter
    import irqc_pkg::*;
#(
    parameter int CNT_W         = 8,
    parameter int DATA_W        = 8,
    parameter int PRE_W         = 10,
    parameter int LINE_DOTS     = 341,
    parameter int DOTS_PER_TICK = 3,
    parameter bit HONOR_REPEAT  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_tick,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              wr_mode,
    input  logic              wr_ack,
    input  logic [DATA_W-1:0] wr_data,
    output logic              irq
);
    localparam int HALF = CNT_W / 2;

    logic [CNT_W-1:0]        latch_q;
    logic [CNT_W-1:0]        cnt_q;
    logic signed [PRE_W-1:0] pre_q;
    mode_t                   mode_q;
    logic                    load, run, pre_step, pre_fire, cnt_step, wrap;
    logic [DATA_W-HALF-1:0]  unused_data_hi;

    assign unused_data_hi = wr_data[DATA_W-1:HALF];

    // Decode the count enables from the stored mode and the incoming tick.
    always_comb begin
        load     = wr_mode && wr_data[EN_BIT];
        run      = cpu_tick && !wr_mode && mode_q.en;
        pre_step = run && !mode_q.cyc;
        cnt_step = run && (mode_q.cyc || pre_fire);
    end

    irqc_regs #(
        .CNT_W        (CNT_W),
        .HONOR_REPEAT (HONOR_REPEAT)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wr_mode (wr_mode),
        .wr_ack  (wr_ack),
        .wr_data (wr_data[HALF-1:0]),
        .latch_q (latch_q),
        .mode_q  (mode_q)
    );

    irqc_prescaler #(
        .PRE_W         (PRE_W),
        .LINE_DOTS     (LINE_DOTS),
        .DOTS_PER_TICK (DOTS_PER_TICK)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (pre_step),
        .fire  (pre_fire),
        .pre_q (pre_q)
    );

    irqc_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (cnt_step),
        .latch (latch_q),
        .wrap  (wrap),
        .cnt_q (cnt_q)
    );

    // Sticky interrupt: set on wrap, cleared by a mode or acknowledge write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (wrap) begin
            irq <= 1'b1;
        end else if (wr_mode || wr_ack) begin
            irq <= 1'b0;
        end
    end

endmodule

// File: rtl/irqc_checker.sv
// Module: irqc_checker
// Temporal checks on the counter, attached to the top module by bind.
// Assumes: the signals are connected from the top module's own scope.
module irqc_checker #(
    parameter int CNT_W     = 8,
    parameter int DATA_W    = 8,
    parameter int PRE_W     = 10,
    parameter int LINE_DOTS = 341
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_lo,
    input logic                    wr_hi,
    input logic                    wr_mode,
    input logic                    wr_ack,
    input logic [DATA_W-1:0]       wr_data,
    input logic                    irq,
    input logic                    en,
    input logic [CNT_W-1:0]        cnt,
    input logic [CNT_W-1:0]        latch,
    input logic signed [PRE_W-1:0] pre
);
    // A mode write that sets enable loads the counter from the latch.
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode && wr_data[1] && !wr_lo && !wr_hi) |=> (cnt == $past(latch)));

    // Any mode write leaves the IRQ low.
    p_mode_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode |=> !irq);

    // A disabled counter holds its value.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !wr_mode) |=> $stable(cnt));

    // The prescaler budget always stays within 0 .. LINE_DOTS.
    p_pre_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pre >= 0) && (pre <= $signed(PRE_W'(LINE_DOTS))));

    // The IRQ rises only when the counter left all-ones and reloaded.
    p_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(cnt) == {CNT_W{1'b1}} && cnt == $past(latch)));

    // The IRQ stays high without a clearing write.
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_mode && !wr_ack) |=> irq);

endmodule

bind irq_tick_counter irqc_checker #(
    .CNT_W     (CNT_W),
    .DATA_W    (DATA_W),
    .PRE_W     (PRE_W),
    .LINE_DOTS (LINE_DOTS)
) u_irqc_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .wr_mode (wr_mode),
    .wr_ack  (wr_ack),
    .wr_data (wr_data),
    .irq     (irq),
    .en      (mode_q.en),
    .cnt     (cnt_q),
    .latch   (latch_q),
    .pre     (pre_q)
);

// File: tb/test_irq_tick_counter.sv
// Bench: a vector table walked by one loop, then directed reset and
// acknowledge-variant tests. Inputs change on the falling edge; the IRQ is
// sampled on the falling edge after the last rising edge of each step.
module test_irq_tick_counter;

    localparam int OP_LO   = 0;
    localparam int OP_HI   = 1;
    localparam int OP_MODE = 2;
    localparam int OP_ACK  = 3;
    localparam int OP_TICK = 4;
    localparam int NVEC    = 30;
    localparam int WD_LIMIT = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_tick = 1'b0;
    logic wr_lo = 1'b0, wr_hi = 1'b0, wr_mode = 1'b0, wr_ack = 1'b0;
    logic [7:0] wr_data = '0;
    logic irq, irq_nr;
    int   n_run = 0;
    int   n_fail = 0;
    int   cycles = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    irq_tick_counter i_irq_tick_counter (
        .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .wr_lo(wr_lo),
        .wr_hi(wr_hi), .wr_mode(wr_mode), .wr_ack(wr_ack),
        .wr_data(wr_data), .irq(irq)
    );

    irq_tick_counter #(.HONOR_REPEAT(1'b0)) i_irq_tick_counter_norep (
        .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .wr_lo(wr_lo),
        .wr_hi(wr_hi), .wr_mode(wr_mode), .wr_ack(wr_ack),
        .wr_data(wr_data), .irq(irq_nr)
    );

    // Entry layout: req[24:21] op[20:18] data[17:10] ticks[9:1] expected irq[0].
    localparam logic [24:0] VEC [NVEC] = '{
        {4'd1, 3'd0, 8'hED, 9'd0,   1'b0},  // R1 low nibble D, data 7:4 ignored
        {4'd1, 3'd1, 8'h3F, 9'd0,   1'b0},  // R1 high nibble F -> latch FD
        {4'd2, 3'd2, 8'h06, 9'd0,   1'b0},  // R2 cycle mode, enable, load FD
        {4'd6, 3'd4, 8'h00, 9'd2,   1'b0},  // R6 FE, FF
        {4'd8, 3'd4, 8'h00, 9'd1,   1'b1},  // R8 wrap raises IRQ
        {4'd9, 3'd4, 8'h00, 9'd3,   1'b1},  // R9 second wrap, still high
        {4'd3, 3'd3, 8'h00, 9'd0,   1'b0},  // R3 ack clears, repeat=0 disables
        {4'd3, 3'd4, 8'h00, 9'd5,   1'b0},  // R3 stopped after ack
        {4'd2, 3'd2, 8'h07, 9'd0,   1'b0},  // R2 repeat+enable+cycle, reload FD
        {4'd6, 3'd4, 8'h00, 9'd3,   1'b1},  // R6 three ticks to IRQ
        {4'd3, 3'd3, 8'h00, 9'd0,   1'b0},  // R3 ack with repeat=1
        {4'd3, 3'd4, 8'h00, 9'd3,   1'b1},  // R3 still running after ack
        {4'd2, 3'd2, 8'h05, 9'd0,   1'b0},  // R2 mode write clears IRQ, no load
        {4'd5, 3'd4, 8'h00, 9'd4,   1'b0},  // R5 disabled, held at FD
        {4'd3, 3'd3, 8'h00, 9'd0,   1'b0},  // R3 ack copies repeat -> enable
        {4'd5, 3'd4, 8'h00, 9'd2,   1'b0},  // R5 counter resumed from FD
        {4'd8, 3'd4, 8'h00, 9'd1,   1'b1},  // R8 wrap
        {4'd9, 3'd0, 8'h0F, 9'd0,   1'b1},  // R9 latch write leaves IRQ
        {4'd9, 3'd1, 8'h0F, 9'd0,   1'b1},  // R9 latch FF, IRQ still high
        {4'd2, 3'd2, 8'h03, 9'd0,   1'b0},  // R2 scanline, enable, repeat
        {4'd7, 3'd4, 8'h00, 9'd113, 1'b0},  // R7 first line not yet done
        {4'd7, 3'd4, 8'h00, 9'd1,   1'b1},  // R7 step at tick 114
        {4'd3, 3'd3, 8'h00, 9'd0,   1'b0},  // R3 ack
        {4'd7, 3'd4, 8'h00, 9'd113, 1'b0},  // R7 second line
        {4'd7, 3'd4, 8'h00, 9'd1,   1'b1},  // R7 step at tick 114
        {4'd3, 3'd3, 8'h00, 9'd0,   1'b0},  // R3 ack
        {4'd7, 3'd4, 8'h00, 9'd112, 1'b0},  // R7 third line
        {4'd7, 3'd4, 8'h00, 9'd1,   1'b1},  // R7 step at tick 113
        {4'd2, 3'd2, 8'h04, 9'd0,   1'b0},  // R2 disable clears IRQ
        {4'd5, 3'd4, 8'h00, 9'd200, 1'b0}   // R5 no counting while disabled
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: irq=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_write(input int op, input logic [7:0] d);
        @(negedge clk);
        wr_data = d;
        wr_lo   = (op == OP_LO);
        wr_hi   = (op == OP_HI);
        wr_mode = (op == OP_MODE);
        wr_ack  = (op == OP_ACK);
        @(negedge clk);
        wr_lo = 1'b0; wr_hi = 1'b0; wr_mode = 1'b0; wr_ack = 1'b0;
    endtask

    task automatic do_ticks(input int n);
        if (n > 0) begin
            @(negedge clk);
            cpu_tick = 1'b1;
            repeat (n) @(negedge clk);
            cpu_tick = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT && !done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WD_LIMIT);
            finish_run();
        end
    end

    initial begin
        do_reset();
        check("R10 reset", irq, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            automatic logic [3:0] req = VEC[i][24:21];
            automatic int         op  = int'(VEC[i][20:18]);
            if (op == OP_TICK) do_ticks(int'(VEC[i][9:1]));
            else               do_write(op, VEC[i][17:10]);
            check($sformatf("R%0d vec%0d", req, i), irq, VEC[i][0]);
        end

        // R10: with no writes after reset, ticks do nothing.
        do_reset();
        do_ticks(300);
        check("R10 idle after reset", irq, 1'b0);

        // R10: reset in the middle of a pending IRQ drops it.
        do_write(OP_LO, 8'h0F);
        do_write(OP_HI, 8'h0F);
        do_write(OP_MODE, 8'h06);
        do_ticks(1);
        check("R8 latch FF wraps on first tick", irq, 1'b1);
        do_reset();
        check("R10 reset clears IRQ", irq, 1'b0);

        // R10: counter starts at 0; enable without reload needs 256 steps.
        // R4: the non-repeat instance stays disabled after the acknowledge.
        do_write(OP_MODE, 8'h05);
        do_write(OP_ACK, 8'h00);
        do_ticks(255);
        check("R10 counter from zero, 255 ticks", irq, 1'b0);
        do_ticks(1);
        check("R10 counter from zero, 256 ticks", irq, 1'b1);
        check("R4 ack leaves enable clear", irq_nr, 1'b0);

        // R4 versus R3: an ack with repeat=0 stops only the repeat-honoring copy.
        do_reset();
        do_write(OP_LO, 8'h0E);
        do_write(OP_HI, 8'h0F);
        do_write(OP_MODE, 8'h06);
        do_write(OP_ACK, 8'h00);
        do_ticks(2);
        check("R3 repeat=0 ack stops counting", irq, 1'b0);
        check("R4 ack keeps enable set", irq_nr, 1'b1);

        finish_run();
    end

endmodule